// File: doc/BRIEF.md
# Board Status and Control Register Block

This block is a small memory-mapped register file for an evaluation board, attached to a 32-bit APB-style peripheral bus with zero wait states. It gives software two read-only identity words (a build-date code and the processor clock rate in Hz), a read/write register that drives the board LEDs, and a read-only view of the DIP switches. It also provides a guarded board reset: one write-only word raises a reset request only when a key value is written to it.

A read is taken in the APB setup phase (select high, enable low, write low). The data is registered and presented during the access phase that follows. A write takes effect in the access phase (select, enable and write all high). The DIP switch lines are asynchronous and pass through a two-flop synchroniser before software can see them. The reset request is a registered single-cycle pulse for an external reset controller.

Top module: `board_ctrl_regs`

## Requirements
- R1: A read of word offset 0x0 returns the build code parameter, 0x09272011 by default.
- R2: A read of word offset 0x4 returns the processor clock parameter in Hz, 10000000 (0x00989680) by default.
- R3: A write to offset 0x8 stores pwdata[LED_W-1:0], and `led` shows it from the cycle after the access phase. A read of 0x8 returns the stored value with bits above LED_W as zero. Bit value 1 means lit.
- R4: Reset clears the LED register to zero, and `prdata` reads zero.
- R5: A read of offset 0xC returns the synchronised DIP switch lines (1 means on) in bits [SW_W-1:0], with zeros above. A switch value held stable for at least two clocks before the setup phase is returned exactly. Writes to 0xC change nothing.
- R6: A write of exactly 0x0000DEAD to offset 0x10 drives `rst_req` high for exactly the one cycle that follows the access phase. Any other value written there leaves `rst_req` low.
- R7: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC, including 0x10, return zero. Writes to 0x0, 0x4, 0xC and unmapped offsets leave `led` unchanged and raise no reset request.
- R8: Only paddr[ADDR_W-1:2] is decoded, and the byte-lane bits paddr[1:0] are ignored. For example, 0x0B addresses the LED register and 0x12 the reset key word.
- R9: Read data is captured on the clock edge that ends the setup phase. It is valid for the whole access phase and holds until the next read.
- R10: `rst_req` is never high while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (16) | Byte address within the 64 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| dip_sw | input | SW_W (8) | Asynchronous DIP switch lines, 1 = on |
| led | output | LED_W (8) | LED drive lines, 1 = lit |
| rst_req | output | 1 | One-cycle board reset request pulse |

## Verification
A corrupted LED register appears on `led` in the cycle after the bad write. It also appears in the next read of 0x8, so the bench compares both the pins and the read-back after every write. A decode fault that aliases one offset onto another shows on the very next read or write to either offset, either as wrong read data or as a stray LED change or reset pulse. A fault in the key comparison or in the pulse register shows within one cycle of a write to 0x10, either as a missing pulse or as a pulse that lasts a second cycle. A stuck synchroniser stage shows as wrong switch data two cycles after a switch change.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BUILD,
        SEL_CLKHZ,
        SEL_LED,
        SEL_SWITCH,
        SEL_RSTKEY
    } reg_sel_e;

    // word indices (byte offset >> 2)
    localparam int unsigned IDX_BUILD  = 0;
    localparam int unsigned IDX_CLKHZ  = 1;
    localparam int unsigned IDX_LED    = 2;
    localparam int unsigned IDX_SWITCH = 3;
    localparam int unsigned IDX_RSTKEY = 4;

    localparam logic [31:0] RESET_KEY = 32'h0000_DEAD;

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.sync;

endmodule

// File: rtl/reg_addr_dec.sv
module reg_addr_dec
    import board_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        if (widx == WIDX_W'(IDX_BUILD))       sel = SEL_BUILD;
        else if (widx == WIDX_W'(IDX_CLKHZ))  sel = SEL_CLKHZ;
        else if (widx == WIDX_W'(IDX_LED))    sel = SEL_LED;
        else if (widx == WIDX_W'(IDX_SWITCH)) sel = SEL_SWITCH;
        else if (widx == WIDX_W'(IDX_RSTKEY)) sel = SEL_RSTKEY;
        else                                  sel = SEL_NONE;
    end

endmodule

// File: rtl/reset_key_gen.sv
module reset_key_gen
    import board_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output logic        req
);

    typedef struct packed {
        logic req;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = wr_en && (sel == SEL_RSTKEY) && (wdata == RESET_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;

    AST_REQ_FOLLOWS_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ($past(wr_en) && $past(sel) == SEL_RSTKEY && $past(wdata) == RESET_KEY)); // R6

    AST_REQ_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !req); // R10

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_regs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned LED_W      = 8,
    parameter int unsigned SW_W       = 8,
    parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
    parameter int unsigned CLK_HZ     = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [SW_W-1:0]   dip_sw,
    output logic [LED_W-1:0]  led,
    output logic              rst_req
);

    localparam logic [31:0] CLK_WORD = 32'(CLK_HZ);

    typedef struct packed {
        logic [LED_W-1:0] led;
        logic [31:0]      rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;

    logic [SW_W-1:0] sw_synced;
    reg_sel_e        sel;
    logic            rd_strobe;
    logic            wr_en;

    assign rd_strobe = psel && !penable && !pwrite;
    assign wr_en     = psel &&  penable &&  pwrite;

    sw_sync #(.W(SW_W)) u_sw_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dip_sw),
        .dout (sw_synced)
    );

    reg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr(paddr),
        .sel (sel)
    );

    reset_key_gen u_key (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .sel  (sel),
        .wdata(pwdata),
        .req  (rst_req)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && sel == SEL_LED) begin
            st_d.led = pwdata[LED_W-1:0];
        end
        if (rd_strobe) begin
            unique case (sel)
                SEL_BUILD:  st_d.rdata = BUILD_CODE;
                SEL_CLKHZ:  st_d.rdata = CLK_WORD;
                SEL_LED:    st_d.rdata = 32'(st_q.led);
                SEL_SWITCH: st_d.rdata = 32'(sw_synced);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign led    = st_q.led;
    assign prdata = st_q.rdata;

    AST_LED_CHANGES_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_LED) |=> $stable(led)); // R7

    AST_LED_TAKES_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LED) |=> led == $past(pwdata[LED_W-1:0])); // R3

    AST_BUILD_CODE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && sel == SEL_BUILD) |=> prdata == BUILD_CODE); // R1

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (sel == SEL_NONE || sel == SEL_RSTKEY)) |=> prdata == 32'h0); // R7

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(prdata)); // R9

endmodule

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned LED_W  = 8;
    localparam int unsigned SW_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              psel, penable, pwrite;
    logic [ADDR_W-1:0] paddr;
    logic [31:0]       pwdata;
    logic [31:0]       prdata;
    logic [SW_W-1:0]   dip_sw;
    logic [LED_W-1:0]  led;
    logic              rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    logic [LED_W-1:0] led_exp;

    always #10 clk = ~clk;

    board_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .dip_sw(dip_sw), .led(led), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1:2])
            14'd0:   return 32'h0927_2011;
            14'd1:   return 32'd10_000_000;
            14'd2:   return 32'(led_exp);
            14'd3:   return 32'(dip_sw);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_pulse(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        return (a[ADDR_W-1:2] == 14'd4) && (d == 32'h0000_DEAD);
    endfunction

    task automatic apb_read(input logic [ADDR_W-1:0] a, input string req);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        check(req, prdata, exp_read(a));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        check({req, " R9 hold"}, prdata, exp_read(a));
    endtask

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
        logic pulse;
        pulse = exp_pulse(a, d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        check({req, " R6 no early pulse"}, 32'(rst_req), 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        if (a[ADDR_W-1:2] == 14'd2) led_exp = d[LED_W-1:0];
        check({req, " R6 pulse"}, 32'(rst_req), 32'(pulse));
        check({req, " R3/R7 led"}, 32'(led), 32'(led_exp));
        @(negedge clk);
        check({req, " R6 single cycle"}, 32'(rst_req), 32'h0);
    endtask

    initial begin
        int cycles = 0;
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20110927));
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        dip_sw = 8'h00; led_exp = '0;
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 led in reset", 32'(led), 32'h0);
        check("R4 prdata in reset", prdata, 32'h0);
        check("R10 no request in reset", 32'(rst_req), 32'h0);
        rst_n = 1'b1;

        apb_read(16'h0000, "R1 build code");
        apb_read(16'h0004, "R2 clock word");
        apb_read(16'h0008, "R4 led after reset");
        apb_write(16'h0008, 32'hFFFF_FFA5, "R3 led write");
        apb_read(16'h0008, "R3 led readback upper zero");
        apb_read(16'h000B, "R8 byte bits ignored on read");
        apb_write(16'h000A, 32'h0000_003C, "R8 byte bits ignored on write");
        dip_sw = 8'h5A; repeat (3) @(negedge clk);
        apb_read(16'h000C, "R5 switches");
        apb_write(16'h000C, 32'h0000_00FF, "R5 switch write ignored");
        apb_read(16'h000C, "R5 switches after write");
        apb_write(16'h0000, 32'h1234_5678, "R7 build write ignored");
        apb_read(16'h0000, "R7 build after write");
        apb_write(16'h0004, 32'h0, "R7 clock write ignored");
        apb_read(16'h0010, "R7 key word reads zero");
        apb_read(16'hFFFC, "R7 unmapped top reads zero");
        apb_write(16'h0010, 32'h0000_DEAD, "R6 key write");
        apb_write(16'h0012, 32'h0000_DEAD, "R8 key write byte bits");
        apb_write(16'h0010, 32'h0001_DEAD, "R6 near-key value");
        apb_write(16'h0010, 32'h0000_DEAC, "R6 near-key value low");
        apb_write(16'h0014, 32'h0000_DEAD, "R7 key at wrong offset");

        for (int i = 0; i < 300; i++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            int kind;
            kind = int'($urandom % 6);
            if (kind < 5) a = ADDR_W'(kind * 4) | ADDR_W'($urandom % 4);
            else          a = ADDR_W'($urandom);
            d = ($urandom % 4 == 0) ? 32'h0000_DEAD : $urandom;
            if ($urandom % 3 == 0) begin
                dip_sw = SW_W'($urandom);
                repeat (3) @(negedge clk);
            end
            if ($urandom % 2 == 0) apb_write(a, d, "R3/R6/R7 random write");
            else                   apb_read(a, "R1/R2/R3/R5/R7 random read");
        end

        // reset in the middle of operation
        apb_write(16'h0008, 32'h0000_00C3, "R3 led before reset");
        @(negedge clk);
        rst_n = 1'b0;
        led_exp = '0;
        @(negedge clk);
        check("R4 led cleared by reset", 32'(led), 32'h0);
        check("R10 no request in reset", 32'(rst_req), 32'h0);
        rst_n = 1'b1;
        apb_read(16'h0008, "R4 led read after reset");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule